// File: doc/BRIEF.md
# Twelve-Line General-Purpose I/O Ports with Direction Control

This block provides twelve general-purpose I/O lines, split into an eight-line port A and a four-line port B. Each port has two registers. The data latch holds the value driven onto output lines. The direction register holds one bit per line: a bit of 1 makes that line an input, and a bit of 0 makes it an output driven from the latch. The pad drivers are modelled as an output-enable vector and an output-value vector for each port. Pull resistors and drive styles belong to the pad cells and are not modelled here.

A byte-wide register interface reaches all four registers. Each cycle it accepts one operation: a full write, a single-bit set, a single-bit clear, or a complement of the whole register. Reading a data register returns a mixed value. Input lines show their synchronized pad level and output lines show their latch bit. The single-bit and complement operations on a data register start from this mixed value and write the result back into the whole latch. So an input line's latch bit picks up the pad level whenever a bit operation touches any line of that port.

Port A lines that are set as inputs can request a wake-up when they fall, if the wake-up enable input is high. Pad inputs pass through a two-flop synchronizer before they are read or used for wake-up detection.

Top module: `gpio_dual_port`

## Requirements
- R1: Register addresses are 0x12 for the port A latch, 0x13 for port A direction, 0x14 for the port B latch and 0x15 for port B direction. With reg_wr_en high and reg_op = 0 (write), reg_wdata loads into the addressed register at the next clock edge. An operation at any other address changes no register.
- R2: A direction bit of 1 drives its pad_*_oe bit low. A direction bit of 0 drives the pad_*_oe bit high, and the line's pad_*_out bit is then the latch bit.
- R3: reg_rdata is combinational from reg_addr. For a latch address, each bit is the synchronized pad level when its direction bit is 1, or the latch bit when its direction bit is 0. For a direction address, it is the direction register. Unmapped addresses read 0.
- R4: A latch keeps its value until a write or bit operation addresses it. This holds while the line is an input, and a stored value appears on pad_*_out when the line becomes an output.
- R5: reg_op = 1 sets bit reg_bit and reg_op = 2 clears bit reg_bit of the value read at the address (the mixed value for a latch, the register for a direction address). The whole result is written back to that register.
- R6: reg_op = 3 complements every bit of the value read at the address and writes the result back.
- R7: Synchronous active-high reset sets every direction bit to 1 (all inputs) and every latch bit to 1.
- R8: A pad change appears in reg_rdata after exactly two clock edges and not after one.
- R9: wake_req pulses high for one cycle, two edges after a falling edge on a port A line whose direction bit is 1, while wake_en is high. A fall on an output line, on port B, or while wake_en is low gives no pulse.
- R10: Bits 7:4 of both port B registers read as 0. Writes to those bits, and bit operations with reg_bit 4 to 7 on port B, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Perform the operation in reg_op this cycle |
| reg_addr | input | 8 | Register byte address |
| reg_op | input | 2 | 0 write, 1 set bit, 2 clear bit, 3 complement |
| reg_bit | input | 3 | Bit index for set and clear |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pad_a_in | input | 8 | Port A pad levels |
| pad_a_oe | output | 8 | Port A output enables |
| pad_a_out | output | 8 | Port A output values |
| pad_b_in | input | 4 | Port B pad levels |
| pad_b_oe | output | 4 | Port B output enables |
| pad_b_out | output | 4 | Port B output values |
| wake_en | input | 1 | Enables wake-up detection |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
A corrupted direction bit shows on pad_*_oe in the cycle after the faulty update. It also changes the source of that bit in reg_rdata at once. A wrong latch bit appears on pad_*_out, but only while the line is an output. For an input line it stays hidden until the line is switched to an output or read back with its direction bit cleared. The directed sequence therefore reads every latch after each direction change. A synchronizer with the wrong depth moves both the read value and the wake pulse by one cycle, so those are sampled at the exact edge count.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    parameter int REG_W  = 8;
    parameter int PA_W   = 8;
    parameter int PB_W   = 4;
    parameter int BIDX_W = $clog2(REG_W);

    parameter logic [7:0] PA_DATA_ADDR = 8'h12;
    parameter logic [7:0] PA_DIR_ADDR  = 8'h13;
    parameter logic [7:0] PB_DATA_ADDR = 8'h14;
    parameter logic [7:0] PB_DIR_ADDR  = 8'h15;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_FLIP  = 2'd3
    } reg_op_e;

    typedef struct packed {
        reg_op_e                 op;
        logic [BIDX_W-1:0]       bidx;
        logic [REG_W-1:0]        wdata;
    } reg_cmd_t;

    function automatic logic [REG_W-1:0] apply_op(
        input logic [REG_W-1:0] base,
        input reg_cmd_t         cmd
    );
        logic [REG_W-1:0] r;
        r = base;
        case (cmd.op)
            OP_WRITE: r = cmd.wdata;
            OP_SET:   r[cmd.bidx] = 1'b1;
            OP_CLEAR: r[cmd.bidx] = 1'b0;
            OP_FLIP:  r = ~base;
            default:  r = base;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] sync_prev
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [W-1:0] stage3;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            stage2 <= '1;
            stage3 <= '1;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    assign sync_out  = stage2;
    assign sync_prev = stage3;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             data_sel,
    input  logic             dir_sel,
    input  reg_cmd_t         cmd,
    input  logic [W-1:0]     pad_sync,
    output logic [W-1:0]     latch_q,
    output logic [W-1:0]     dir_q,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] rd_dir
);
    logic [W-1:0]     mixed;
    logic [REG_W-1:0] data_next;
    logic [REG_W-1:0] dir_next;

    always_comb begin
        for (int i = 0; i < W; i++)
            mixed[i] = dir_q[i] ? pad_sync[i] : latch_q[i];
        rd_data = '0;
        rd_data[W-1:0] = mixed;
        rd_dir = '0;
        rd_dir[W-1:0] = dir_q;
        data_next = apply_op(rd_data, cmd);
        dir_next  = apply_op(rd_dir, cmd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
            dir_q   <= '1;
        end else begin
            if (data_sel) latch_q <= data_next[W-1:0];
            if (dir_sel)  dir_q   <= dir_next[W-1:0];
        end
    end

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !data_sel |=> $stable(latch_q));

    assert_dir_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !dir_sel |=> $stable(dir_q));

    assert_reset_state_R7: assert property (@(posedge clk)
        $past(rst) |-> (latch_q == '1 && dir_q == '1));
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wake_en,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] level_now,
    input  logic [W-1:0] level_prev,
    output logic         wake_req
);
    logic [W-1:0] fall_hit;

    generate
        for (genvar g = 0; g < W; g++) begin : g_line
            assign fall_hit[g] = dir_q[g] & level_prev[g] & ~level_now[g];
        end
    endgenerate

    assign wake_req = wake_en & (|fall_hit);

    assert_no_wake_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !wake_en |-> !wake_req);
endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port
    import gpio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_addr,
    input  logic [1:0]  reg_op,
    input  logic [2:0]  reg_bit,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [7:0]  pad_a_in,
    output logic [7:0]  pad_a_oe,
    output logic [7:0]  pad_a_out,
    input  logic [3:0]  pad_b_in,
    output logic [3:0]  pad_b_oe,
    output logic [3:0]  pad_b_out,
    input  logic        wake_en,
    output logic        wake_req
);
    reg_cmd_t         cmd;
    logic [PA_W-1:0]  a_sync, a_prev, a_latch, a_dir;
    logic [PB_W-1:0]  b_sync, b_prev, b_latch, b_dir;
    logic [REG_W-1:0] a_rd_data, a_rd_dir, b_rd_data, b_rd_dir;

    assign cmd.op    = reg_op_e'(reg_op);
    assign cmd.bidx  = reg_bit;
    assign cmd.wdata = reg_wdata;

    gpio_sync #(.W(PA_W)) u_sync_a (
        .clk(clk), .rst(rst), .async_in(pad_a_in),
        .sync_out(a_sync), .sync_prev(a_prev));

    gpio_sync #(.W(PB_W)) u_sync_b (
        .clk(clk), .rst(rst), .async_in(pad_b_in),
        .sync_out(b_sync), .sync_prev(b_prev));

    gpio_port #(.W(PA_W)) u_port_a (
        .clk(clk), .rst(rst),
        .data_sel(reg_wr_en && reg_addr == PA_DATA_ADDR),
        .dir_sel(reg_wr_en && reg_addr == PA_DIR_ADDR),
        .cmd(cmd), .pad_sync(a_sync),
        .latch_q(a_latch), .dir_q(a_dir),
        .rd_data(a_rd_data), .rd_dir(a_rd_dir));

    gpio_port #(.W(PB_W)) u_port_b (
        .clk(clk), .rst(rst),
        .data_sel(reg_wr_en && reg_addr == PB_DATA_ADDR),
        .dir_sel(reg_wr_en && reg_addr == PB_DIR_ADDR),
        .cmd(cmd), .pad_sync(b_sync),
        .latch_q(b_latch), .dir_q(b_dir),
        .rd_data(b_rd_data), .rd_dir(b_rd_dir));

    gpio_wake #(.W(PA_W)) u_wake (
        .clk(clk), .rst(rst), .wake_en(wake_en), .dir_q(a_dir),
        .level_now(a_sync), .level_prev(a_prev), .wake_req(wake_req));

    always_comb begin
        case (reg_addr)
            PA_DATA_ADDR: reg_rdata = a_rd_data;
            PA_DIR_ADDR:  reg_rdata = a_rd_dir;
            PB_DATA_ADDR: reg_rdata = b_rd_data;
            PB_DIR_ADDR:  reg_rdata = b_rd_dir;
            default:      reg_rdata = '0;
        endcase
    end

    assign pad_a_oe  = ~a_dir;
    assign pad_a_out = a_latch;
    assign pad_b_oe  = ~b_dir;
    assign pad_b_out = b_latch;

    // b_prev is only carried for symmetry of the synchronizer interface
    logic unused_b_prev;
    assign unused_b_prev = ^b_prev;

    assert_b_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == PB_DATA_ADDR || reg_addr == PB_DIR_ADDR) |-> reg_rdata[7:4] == 4'h0);

    assert_wake_needs_input_R9: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (|pad_a_oe == 1'b0 || pad_a_oe != 8'hFF));

    assert_unmapped_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr < PA_DATA_ADDR || reg_addr > PB_DIR_ADDR) |-> reg_rdata == 8'h00);
endmodule

// File: tb/test_gpio_dual_port.sv
module test_gpio_dual_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [1:0] reg_op = 2'd0;
    logic [2:0] reg_bit = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pad_a_in = 8'h3C;
    logic [7:0] pad_a_oe, pad_a_out;
    logic [3:0] pad_b_in = 4'h0;
    logic [3:0] pad_b_oe, pad_b_out;
    logic       wake_en = 1'b0;
    logic       wake_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gpio_dual_port i_gpio_dual_port (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_op(reg_op), .reg_bit(reg_bit), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pad_a_in(pad_a_in), .pad_a_oe(pad_a_oe),
        .pad_a_out(pad_a_out), .pad_b_in(pad_b_in), .pad_b_oe(pad_b_oe),
        .pad_b_out(pad_b_out), .wake_en(wake_en), .wake_req(wake_req));

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic op(logic [7:0] addr, logic [1:0] o, logic [2:0] b, logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = addr; reg_op = o; reg_bit = b; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] addr, output logic [7:0] v);
        reg_addr = addr;
        #1 v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R7 oe_a", pad_a_oe, 8'h00);
        check("R7 out_a", pad_a_out, 8'hFF);
        check("R7 out_b", {4'h0, pad_b_out}, 8'h0F);
        rd(8'h13, v); check("R7 dir_a", v, 8'hFF);
        rd(8'h15, v); check("R7 dir_b", v, 8'h0F);
    endtask

    task automatic t_direction_and_read;
        logic [7:0] v;
        op(8'h13, 2'd0, 3'd0, 8'h0F);
        op(8'h12, 2'd0, 3'd0, 8'hA5);
        check("R2 oe_a", pad_a_oe, 8'hF0);
        check("R2 out_a", pad_a_out, 8'hA5);
        rd(8'h12, v); check("R3 mixed read", v, 8'hAC);
        op(8'h16, 2'd0, 3'd0, 8'h00);
        op(8'h11, 2'd3, 3'd0, 8'h00);
        rd(8'h12, v); check("R1 unmapped no effect data", v, 8'hAC);
        rd(8'h13, v); check("R1 unmapped no effect dir", v, 8'h0F);
        rd(8'h16, v); check("R3 unmapped reads 0", v, 8'h00);
    endtask

    task automatic t_latch_hold;
        logic [7:0] v;
        pad_a_in = 8'hC3;
        cycles(4);
        check("R4 latch held", pad_a_out, 8'hA5);
        op(8'h13, 2'd0, 3'd0, 8'h00);
        rd(8'h12, v); check("R4 hidden latch bits", v, 8'hA5);
        op(8'h13, 2'd0, 3'd0, 8'h0F);
        pad_a_in = 8'h3C;
        cycles(3);
    endtask

    task automatic t_bit_ops;
        logic [7:0] v;
        op(8'h12, 2'd1, 3'd7, 8'h00);
        check("R5 set pulls pad into latch", pad_a_out, 8'hAC);
        op(8'h12, 2'd2, 3'd5, 8'h00);
        check("R5 clear bit", pad_a_out, 8'h8C);
        op(8'h13, 2'd1, 3'd7, 8'h00);
        rd(8'h13, v); check("R5 set on dir", v, 8'h8F);
        check("R5 oe after dir set", pad_a_oe, 8'h70);
        op(8'h12, 2'd3, 3'd0, 8'h00);
        check("R6 complement", pad_a_out, 8'hF3);
    endtask

    task automatic t_port_b;
        logic [7:0] v;
        op(8'h15, 2'd0, 3'd0, 8'hF0);
        rd(8'h15, v); check("R10 dir_b upper ignored", v, 8'h00);
        check("R2 oe_b", {4'h0, pad_b_oe}, 8'h0F);
        op(8'h14, 2'd0, 3'd0, 8'hFA);
        rd(8'h14, v); check("R10 data_b upper ignored", v, 8'h0A);
        op(8'h14, 2'd1, 3'd6, 8'h00);
        rd(8'h14, v); check("R10 high bit op no effect", v, 8'h0A);
        op(8'h14, 2'd1, 3'd0, 8'h00);
        check("R5 set on port B", {4'h0, pad_b_out}, 8'h0B);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        op(8'h13, 2'd0, 3'd0, 8'h8F);
        pad_a_in = 8'h3D;
        cycles(1);
        rd(8'h12, v); check("R8 not after one edge", {7'h0, v[0]}, 8'h00);
        cycles(1);
        rd(8'h12, v); check("R8 after two edges", {7'h0, v[0]}, 8'h01);
    endtask

    task automatic t_wake;
        wake_en = 1'b1;
        pad_a_in = 8'h39;
        cycles(1);
        check("R9 no pulse at one edge", {7'h0, wake_req}, 8'h00);
        cycles(1);
        check("R9 pulse on input fall", {7'h0, wake_req}, 8'h01);
        cycles(1);
        check("R9 one cycle pulse", {7'h0, wake_req}, 8'h00);
        pad_a_in = 8'h29;
        cycles(2);
        check("R9 output line no wake", {7'h0, wake_req}, 8'h00);
        pad_b_in = 4'hF;
        cycles(3);
        pad_b_in = 4'h0;
        cycles(2);
        check("R9 port B no wake", {7'h0, wake_req}, 8'h00);
        wake_en = 1'b0;
        pad_a_in = 8'h21;
        cycles(2);
        check("R9 disabled no wake", {7'h0, wake_req}, 8'h00);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);
        t_reset();
        t_direction_and_read();
        t_latch_hold();
        t_bit_ops();
        t_port_b();
        t_sync();
        t_wake();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule